// File: doc/BRIEF.md
# SPI Master Chip-Select Timing Sequencer

This block sets the timing of SPI master frames around the serial clock. It does not shift data and does not produce SCK. It drives the active-low chip-select, opens a window in which the shifter may clock SCK, and reports whether a frame is in progress. Three programmable intervals are counted in system-clock cycles:

- the setup interval, from chip-select assertion to the opening of the SCK window;
- the hold interval, from the shifter's frame-done pulse to chip-select negation;
- the idle gap, from negation to the next assertion.

Each interval is the product of a small odd prescaler and a power-of-two scaler, each selected by a code. In continuous-clock mode the gap instead lasts one SCK period, and that period is supplied as a cycle count.

A frame starts when the start request is sampled high while master operation is enabled. The sequencer moves through setup, transfer, hold and gap. If a start request is sampled high at the end of the gap, the next frame's setup follows directly. Otherwise the sequencer returns to idle.

Top module: `spi_cs_sequencer`

## Requirements
- R1: While reset is high, and in the cycle after it, cs_n_o is 1, sck_en_o is 0 and busy_o is 0.
- R2: After a start is accepted, cs_n_o is 0, busy_o is 1 and sck_en_o is 0 for exactly P*S cycles. P = 2c+1 for setup prescaler code c, giving 1, 3, 5 or 7. S = 2^(n+1) for setup scaler code n, giving 2 to 65536.
- R3: After setup, sck_en_o is 1 with cs_n_o at 0 until frame_done_i is sampled high; the cycle after that sample sck_en_o is 0.
- R4: After frame_done_i, cs_n_o stays 0 with sck_en_o at 0 for exactly the hold product of its own codes, computed as in R2.
- R5: After hold, cs_n_o is 1 and busy_o is 1 for exactly the gap product of its own codes, computed as in R2.
- R6: When the latched continuous mode is 1, the gap lasts sck_period_i cycles (0 counts as 1), and the gap codes are ignored.
- R7: A start request sampled high in the last gap cycle starts setup in the next cycle, with no idle cycle in between.
- R8: The hold codes, gap codes, continuous mode and SCK period are captured when the frame starts. Later changes have no effect on that frame.
- R9: While master_en_i is 0, a start request is ignored and the sequencer stays idle.
- R10: frame_done_i has no effect outside the transfer phase.
- R11: In idle, busy_o is 0, cs_n_o is 1 and sck_en_o is 0. A start sampled in idle drives cs_n_o to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en_i | input | 1 | Master operation enable; a start is accepted only when 1 |
| start_i | input | 1 | Frame start request (level sampled in idle and at gap end) |
| cont_mode_i | input | 1 | Continuous-clock mode; gap becomes one SCK period |
| frame_done_i | input | 1 | Pulse from the shifter: last SCK edge has occurred |
| setup_pre_i | input | PRE_W | Setup prescaler code |
| setup_scl_i | input | SCL_W | Setup scaler code |
| hold_pre_i | input | PRE_W | Hold prescaler code |
| hold_scl_i | input | SCL_W | Hold scaler code |
| gap_pre_i | input | PRE_W | Gap prescaler code |
| gap_scl_i | input | SCL_W | Gap scaler code |
| sck_period_i | input | SCKP_W | SCK period in system cycles, used for the gap in continuous mode |
| cs_n_o | output | 1 | Chip-select, active low |
| sck_en_o | output | 1 | SCK window enable for the shifter |
| busy_o | output | 1 | High from frame start to end of gap |

## Verification
Two events can coincide on one edge: the gap's final cycle can meet a pending start request, and a new frame's code capture can meet a change of those codes. The bench holds start high through the gap end to chain frames back to back. It then rewrites every delay code and the mode flag one cycle after a frame starts. Each chained frame is judged cycle by cycle against the lengths computed from the codes in force at its first edge, and the judging checks that no idle cycle is inserted.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_HOLD,
    ST_GAP
  } seq_state_t;

  typedef struct packed {
    logic cs_n;
    logic sck_en;
    logic busy;
  } seq_out_t;

  // Output pattern that belongs to each phase
  function automatic seq_out_t phase_outputs(seq_state_t s);
    seq_out_t o;
    case (s)
      ST_SETUP: o = '{cs_n: 1'b0, sck_en: 1'b0, busy: 1'b1};
      ST_XFER:  o = '{cs_n: 1'b0, sck_en: 1'b1, busy: 1'b1};
      ST_HOLD:  o = '{cs_n: 1'b0, sck_en: 1'b0, busy: 1'b1};
      ST_GAP:   o = '{cs_n: 1'b1, sck_en: 1'b0, busy: 1'b1};
      default:  o = '{cs_n: 1'b1, sck_en: 1'b0, busy: 1'b0};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/spi_seq_delay_calc.sv
module spi_seq_delay_calc #(
  parameter int PRE_W = 2,
  parameter int SCL_W = 4,
  parameter int DLY_W = PRE_W + 1 + (1 << SCL_W)
) (
  input  logic [PRE_W-1:0] pre_code_i,
  input  logic [SCL_W-1:0] scl_code_i,
  output logic [DLY_W-1:0] cycles_o
);
  // odd prescaler 2c+1, scaler 2^(n+1)
  logic [PRE_W:0] pre_val;
  assign pre_val  = {pre_code_i, 1'b1};
  assign cycles_o = (DLY_W'(pre_val) << 1) << scl_code_i;
endmodule

// File: rtl/spi_seq_counter.sv
module spi_seq_counter #(
  parameter int DLY_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [DLY_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i - DLY_W'(1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - DLY_W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
  import spi_seq_pkg::*;
#(
  parameter int PRE_W  = 2,
  parameter int SCL_W  = 4,
  parameter int SCKP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_en_i,
  input  logic              start_i,
  input  logic              cont_mode_i,
  input  logic              frame_done_i,
  input  logic [PRE_W-1:0]  setup_pre_i,
  input  logic [SCL_W-1:0]  setup_scl_i,
  input  logic [PRE_W-1:0]  hold_pre_i,
  input  logic [SCL_W-1:0]  hold_scl_i,
  input  logic [PRE_W-1:0]  gap_pre_i,
  input  logic [SCL_W-1:0]  gap_scl_i,
  input  logic [SCKP_W-1:0] sck_period_i,
  output logic              cs_n_o,
  output logic              sck_en_o,
  output logic              busy_o
);
  localparam int DLY_W  = PRE_W + 1 + (1 << SCL_W);
  localparam int NDLY   = 3;
  localparam int D_SET  = 0;
  localparam int D_HOLD = 1;
  localparam int D_GAP  = 2;

  seq_state_t state_q, state_d;
  seq_out_t   out_q;

  // codes captured at frame start
  logic [PRE_W-1:0]  hold_pre_q, gap_pre_q;
  logic [SCL_W-1:0]  hold_scl_q, gap_scl_q;
  logic              cont_q;
  logic [SCKP_W-1:0] per_q;

  logic [PRE_W-1:0] pre_src [NDLY];
  logic [SCL_W-1:0] scl_src [NDLY];
  logic [DLY_W-1:0] dly_cyc [NDLY];

  // setup length is loaded on the capture edge, so it uses live codes
  assign pre_src[D_SET]  = setup_pre_i;
  assign scl_src[D_SET]  = setup_scl_i;
  assign pre_src[D_HOLD] = hold_pre_q;
  assign scl_src[D_HOLD] = hold_scl_q;
  assign pre_src[D_GAP]  = gap_pre_q;
  assign scl_src[D_GAP]  = gap_scl_q;

  for (genvar g = 0; g < NDLY; g++) begin : g_calc
    spi_seq_delay_calc #(
      .PRE_W(PRE_W), .SCL_W(SCL_W), .DLY_W(DLY_W)
    ) u_calc (
      .pre_code_i(pre_src[g]),
      .scl_code_i(scl_src[g]),
      .cycles_o  (dly_cyc[g])
    );
  end

  logic [DLY_W-1:0] per_ext, gap_len;
  assign per_ext = {{(DLY_W-SCKP_W){1'b0}}, per_q};
  assign gap_len = !cont_q         ? dly_cyc[D_GAP] :
                   (per_q == '0)   ? DLY_W'(1)      : per_ext;

  logic             go;
  logic             cnt_load;
  logic [DLY_W-1:0] cnt_val;
  logic             cnt_exp;
  logic             capture;

  assign go = master_en_i && start_i;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = dly_cyc[D_SET];
    capture  = 1'b0;
    case (state_q)
      ST_IDLE: if (go) begin
        state_d  = ST_SETUP;
        cnt_load = 1'b1;
        capture  = 1'b1;
      end
      ST_SETUP: if (cnt_exp) state_d = ST_XFER;
      ST_XFER: if (frame_done_i) begin
        state_d  = ST_HOLD;
        cnt_load = 1'b1;
        cnt_val  = dly_cyc[D_HOLD];
      end
      ST_HOLD: if (cnt_exp) begin
        state_d  = ST_GAP;
        cnt_load = 1'b1;
        cnt_val  = gap_len;
      end
      ST_GAP: if (cnt_exp) begin
        if (go) begin
          state_d  = ST_SETUP;
          cnt_load = 1'b1;
          capture  = 1'b1;
        end else begin
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  spi_seq_counter #(.DLY_W(DLY_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load_i    (cnt_load),
    .load_val_i(cnt_val),
    .expired_o (cnt_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      out_q      <= phase_outputs(ST_IDLE);
      hold_pre_q <= '0;
      hold_scl_q <= '0;
      gap_pre_q  <= '0;
      gap_scl_q  <= '0;
      cont_q     <= 1'b0;
      per_q      <= '0;
    end else begin
      state_q <= state_d;
      out_q   <= phase_outputs(state_d);
      if (capture) begin
        hold_pre_q <= hold_pre_i;
        hold_scl_q <= hold_scl_i;
        gap_pre_q  <= gap_pre_i;
        gap_scl_q  <= gap_scl_i;
        cont_q     <= cont_mode_i;
        per_q      <= sck_period_i;
      end
    end
  end

  assign cs_n_o   = out_q.cs_n;
  assign sck_en_o = out_q.sck_en;
  assign busy_o   = out_q.busy;
endmodule

// File: rtl/spi_cs_sequencer_chk.sv
module spi_cs_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic master_en_i,
  input logic cs_n_o,
  input logic sck_en_o,
  input logic busy_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cs_n_o && !sck_en_o && !busy_o));

  // R3
  window_inside_cs_chk: assert property (@(posedge clk) disable iff (rst)
    sck_en_o |-> !cs_n_o);

  // R11
  idle_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (cs_n_o && !sck_en_o));

  // R2
  setup_before_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_en_o) |-> $past(!cs_n_o));

  // R4
  hold_before_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> $past(!sck_en_o));

  // R5
  gap_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> busy_o);

  // R9
  no_start_as_slave_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !master_en_i) |=> !busy_o);
endmodule

bind spi_cs_sequencer spi_cs_sequencer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .master_en_i(master_en_i),
  .cs_n_o     (cs_n_o),
  .sck_en_o   (sck_en_o),
  .busy_o     (busy_o)
);

// File: tb/spi_cs_sequencer_bench.sv
`timescale 1ns/100ps
module spi_cs_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       master_en = 1'b1, start = 1'b0, cont_mode = 1'b0, frame_done = 1'b0;
  logic [1:0] setup_pre = '0, hold_pre = '0, gap_pre = '0;
  logic [3:0] setup_scl = '0, hold_scl = '0, gap_scl = '0;
  logic [7:0] sck_period = '0;
  logic       cs_n, sck_en, busy;

  always #2.5 clk = ~clk;

  spi_cs_sequencer u_spi_cs_sequencer (
    .clk(clk), .rst(rst), .master_en_i(master_en), .start_i(start),
    .cont_mode_i(cont_mode), .frame_done_i(frame_done),
    .setup_pre_i(setup_pre), .setup_scl_i(setup_scl),
    .hold_pre_i(hold_pre), .hold_scl_i(hold_scl),
    .gap_pre_i(gap_pre), .gap_scl_i(gap_scl),
    .sck_period_i(sck_period),
    .cs_n_o(cs_n), .sck_en_o(sck_en), .busy_o(busy)
  );

  // {cs_n, sck_en, busy}
  localparam logic [2:0] V_IDLE = 3'b100, V_SETUP = 3'b001, V_XFER = 3'b011,
                         V_HOLD = 3'b001, V_GAP = 3'b101;

  logic [2:0] exp_q[$];
  string      tag_q[$];
  int         n_vec = 0, n_bad = 0;
  bit         done = 1'b0;

  // monitor: compare one expected item per clock edge
  initial forever begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if ({cs_n, sck_en, busy} !== e) begin
        n_bad++;
        $display("FAIL %s at %0t: {cs_n,sck_en,busy} got %b expected %b",
                 t, $time, {cs_n, sck_en, busy}, e);
      end
    end
  end

  task automatic step(input logic [2:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
  endtask

  function automatic int prod(input int p, input int s);
    return (2 * p + 1) * (2 << s);
  endfunction

  task automatic frame(input int sp, input int ss, input int hp, input int hs,
                       input int gp, input int gs, input bit cont, input int per,
                       input int t_x, input bit chg, input bit fd_setup,
                       input string ft);
    int s_n, h_n, g_n;
    s_n = prod(sp, ss);
    h_n = prod(hp, hs);
    g_n = cont ? ((per == 0) ? 1 : per) : prod(gp, gs);
    setup_pre = 2'(sp); setup_scl = 4'(ss);
    hold_pre  = 2'(hp); hold_scl  = 4'(hs);
    gap_pre   = 2'(gp); gap_scl   = 4'(gs);
    cont_mode = cont;   sck_period = 8'(per);
    start = 1'b1;
    for (int i = 0; i < s_n; i++) begin
      step(V_SETUP, {ft, " R2"});
      start = 1'b0;
      if (chg && i == 0) begin  // R8: rewrite everything mid-frame
        hold_pre = ~hold_pre; hold_scl = hold_scl + 4'd3;
        gap_pre  = ~gap_pre;  gap_scl  = gap_scl + 4'd2;
        cont_mode = ~cont_mode; sck_period = sck_period + 8'd9;
      end
      if (fd_setup) frame_done = 1'b1;  // R10: ignored in setup
    end
    frame_done = 1'b0;
    for (int i = 0; i < t_x; i++) step(V_XFER, {ft, " R3"});
    frame_done = 1'b1;
    step(V_HOLD, {ft, " R3 R4"});
    frame_done = 1'b0;
    for (int i = 1; i < h_n; i++) step(V_HOLD, {ft, " R4"});
    for (int i = 0; i < g_n; i++) step(V_GAP, {ft, cont ? " R6" : " R5"});
  endtask

  initial begin
    @(negedge clk);
    // R1
    for (int i = 0; i < 3; i++) step(V_IDLE, "R1");
    rst = 1'b0;
    step(V_IDLE, "R1");
    // R11 idle, start ignored while not requested
    for (int i = 0; i < 3; i++) step(V_IDLE, "R11");
    frame(0, 0, 0, 0, 0, 0, 1'b0, 0, 3, 1'b0, 1'b0, "R11 minimal");
    for (int i = 0; i < 2; i++) step(V_IDLE, "R11");
    // R8 codes captured at start
    frame(1, 1, 2, 0, 3, 2, 1'b0, 4, 5, 1'b1, 1'b0, "R8");
    step(V_IDLE, "R8");
    // R7 back-to-back frames, the second with different codes
    frame(2, 1, 0, 1, 1, 0, 1'b0, 0, 2, 1'b0, 1'b0, "R7 first");
    frame(0, 2, 1, 0, 0, 1, 1'b0, 0, 4, 1'b1, 1'b0, "R7 chained");
    step(V_IDLE, "R7");
    // R6 continuous mode, large gap codes ignored
    frame(0, 0, 0, 0, 3, 5, 1'b1, 5, 3, 1'b0, 1'b0, "R6");
    frame(0, 0, 0, 0, 3, 5, 1'b1, 1, 2, 1'b1, 1'b0, "R6 chained");
    step(V_IDLE, "R6");
    // R10 frame_done during setup
    frame(1, 0, 0, 0, 0, 0, 1'b0, 0, 6, 1'b0, 1'b1, "R10");
    step(V_IDLE, "R10");
    // R9 master disabled
    master_en = 1'b0;
    start = 1'b1;
    for (int i = 0; i < 10; i++) step(V_IDLE, "R9");
    start = 1'b0;
    master_en = 1'b1;
    step(V_IDLE, "R9");
    // R2 large scaler
    frame(3, 8, 0, 0, 0, 0, 1'b0, 0, 2, 1'b0, 1'b0, "R2 large");
    step(V_IDLE, "R2");
    while (exp_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule